// File: doc/BRIEF.md
# Power-On Memory Initialization Sequencer

This block runs the start-up phase of a signal-processing core after its active-low reset is released. From one shared cycle counter it fills the program memory and the coefficient memory from their boot images, and it clears the working-data memory. The register file is held at zero until the block finishes. The whole sequence lasts a fixed number of clock cycles, counted from the first clock edge that sees reset released. This gives software a start-up time it can rely on, whatever the memory depths are.

Both boot images are read-only memories with a combinational read port. The block presents an address, and the word is used in the same cycle. The three memories are written one address per cycle, all in parallel, starting at address 0. When the longest of them is full, the block waits idle until the fixed count has run out. Host control writes that arrive before the end of the sequence are refused and reported on a one-cycle error flag. After the sequence they are passed through. A reset asserted in the middle of the sequence abandons it, and the next release starts again from cycle zero.

Top module: `boot_init_seq`

## Requirements
- R1: At every clock edge that samples `rst_n` low, the block takes its reset state. From the next cycle `busy` = 1 and all three memory write strobes = 0, and this state holds for as long as reset stays low.
- R2: Cycle k is the k-th cycle after the first edge that sees `rst_n` high, with k starting at 0. `busy` is high in cycles 0 to INIT_CYCLES-1. It is low from cycle INIT_CYCLES on, and it stays low until the next reset.
- R3: In cycle k, for k below PROG_DEPTH, the block drives `prog_rom_addr` = k, `prog_we` = 1, `prog_addr` = k and `prog_wdata` = the image word read at address k.
- R4: In cycle k, for k below COEF_DEPTH, the block drives `coef_rom_addr` = k, `coef_we` = 1, `coef_addr` = k and `coef_wdata` = the image word read at address k.
- R5: In cycle k, for k below DATA_DEPTH, the block drives `data_we` = 1, `data_addr` = k and `data_wdata` = 0.
- R6: Each memory is written exactly once per address, in ascending order. Its write strobe is 0 in every cycle at or after its depth, and always 0 once `busy` is low.
- R7: `regs_clear` is 1 in every cycle where `busy` is 1, and 0 in every cycle where `busy` is 0.
- R8: `host_wr_grant` is 1 in a cycle only when `host_wr_req` is 1 and `busy` is 0 in that same cycle, and it follows `host_wr_req` combinationally once `busy` is low.
- R9: When `host_wr_req` is 1 in a cycle where `busy` is 1 and reset is released, `host_wr_err` is 1 in the next cycle. In any other case `host_wr_err` is 0.
- R10: Asserting reset during the sequence stops all memory writes from the next cycle. After the following release, the full sequence runs again from address 0 and lasts INIT_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_rom_addr | output | PROG_AW | Program boot image read address |
| prog_rom_data | input | PROG_W | Program boot image word (combinational read) |
| prog_we | output | 1 | Program memory write strobe |
| prog_addr | output | PROG_AW | Program memory write address |
| prog_wdata | output | PROG_W | Program memory write data |
| coef_rom_addr | output | COEF_AW | Coefficient boot image read address |
| coef_rom_data | input | COEF_W | Coefficient boot image word (combinational read) |
| coef_we | output | 1 | Coefficient memory write strobe |
| coef_addr | output | COEF_AW | Coefficient memory write address |
| coef_wdata | output | COEF_W | Coefficient memory write data |
| data_we | output | 1 | Data memory write strobe |
| data_addr | output | DATA_AW | Data memory write address |
| data_wdata | output | DATA_W | Data memory write data (always zero) |
| regs_clear | output | 1 | Holds the control registers at zero |
| busy | output | 1 | Initialization in progress |
| host_wr_req | input | 1 | Host control write request |
| host_wr_grant | output | 1 | Host write allowed this cycle |
| host_wr_err | output | 1 | A request was refused in the previous cycle |

## Verification
The bench builds the block with INIT_CYCLES = 64, PROG_DEPTH = 20, COEF_DEPTH = 12 and DATA_DEPTH = 40, with words 16, 12 and 8 bits wide. With these values a complete sequence takes a few dozen cycles, so the bench can check every single cycle of it. The three depths all differ and are all below the count, so each write window closes at its own cycle. The idle wait is also visible, and so are the exact cycle where `busy` falls and a reset that interrupts the sequence partway through the load.

// File: rtl/boot_init_pkg.sv
// Package: shared types and helpers for the start-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package boot_init_pkg;

    // Sequencer phases; READY is the only phase where host writes pass.
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_WAIT  = 2'd2,
        PH_READY = 2'd3
    } init_phase_t;

    // Address or counter width for n distinct values, at least one bit.
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_timer.sv
// Module: init_timer
// Counts the fixed start-up window and walks the phase machine
// HOLD -> LOAD -> WAIT -> READY. The first edge that sees reset released
// moves HOLD to LOAD with the count at 0. The count then advances once
// per cycle. READY is entered on the edge after the count reaches
// INIT_CYCLES-1, and it is kept until reset.
// Assumes: 1 <= LOAD_CYCLES <= INIT_CYCLES, INIT_CYCLES >= 2.
module init_timer
    import boot_init_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 8192,
    parameter int unsigned LOAD_CYCLES = 2048,
    localparam int unsigned CW         = width_for(INIT_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          ready
);

    localparam logic [CW-1:0] LAST_CNT = CW'(INIT_CYCLES - 1);
    localparam logic [CW-1:0] LOAD_END = CW'(LOAD_CYCLES - 1);

    init_phase_t phase_q;
    logic [CW-1:0] cnt_q;

    // Phase and counter update with a synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_HOLD: begin
                    phase_q <= PH_LOAD;
                    cnt_q   <= '0;
                end
                PH_LOAD: begin
                    if (cnt_q == LAST_CNT) begin
                        phase_q <= PH_READY;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                        if (cnt_q == LOAD_END) begin
                            phase_q <= PH_WAIT;
                        end
                    end
                end
                PH_WAIT: begin
                    if (cnt_q == LAST_CNT) begin
                        phase_q <= PH_READY;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    phase_q <= PH_READY;
                end
            endcase
        end
    end

    // Decode the phase into the strobes shared by the lanes.
    always_comb begin
        cnt     = cnt_q;
        running = (phase_q == PH_LOAD) || (phase_q == PH_WAIT);
        ready   = (phase_q == PH_READY);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT); // R2

    AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_q != LAST_CNT) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R2

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R2

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cnt_q) == LAST_CNT && $past(running))); // R2

endmodule

// File: rtl/rom_copy_lane.sv
// Module: rom_copy_lane
// Copies a boot image into its memory, one word per cycle, while the
// shared count lies below DEPTH. The image address and the memory write
// address are both the count, and the image word is written in the same
// cycle.
// Assumes: the image has a combinational read port and DEPTH <= the count
// range, so the low count bits form the address.
module rom_copy_lane
    import boot_init_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned DW    = 32,
    parameter int unsigned CW    = 13,
    localparam int unsigned AW   = width_for(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata
);

    logic in_window;

    // Open the write window while the count is inside the image.
    always_comb begin
        in_window = running && (32'(cnt) < DEPTH);
        rom_addr  = in_window ? cnt[AW-1:0] : '0;
        ram_we    = in_window;
        ram_addr  = rom_addr;
        ram_wdata = in_window ? rom_data : '0;
    end

    AST_COPY_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + AW'(1))); // R3

    AST_COPY_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> (ram_addr == '0)); // R10

endmodule

// File: rtl/zero_fill_lane.sv
// Module: zero_fill_lane
// Writes zero to every address of the working-data memory, one address
// per cycle, while the shared count lies below DEPTH.
// Assumes: DEPTH <= the count range.
module zero_fill_lane
    import boot_init_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned DW    = 24,
    parameter int unsigned CW    = 13,
    localparam int unsigned AW   = width_for(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata
);

    // Drive the clearing write while the count is inside the memory.
    always_comb begin
        ram_we    = running && (32'(cnt) < DEPTH);
        ram_addr  = ram_we ? cnt[AW-1:0] : '0;
        ram_wdata = '0;
    end

    AST_FILL_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + AW'(1))); // R5

    AST_FILL_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> (ram_addr == '0)); // R10

endmodule

// File: rtl/host_write_gate.sv
// Module: host_write_gate
// Passes host control writes only once the sequence is finished. A request
// seen while the sequence runs is dropped, and it raises the error flag in
// the following cycle.
// Assumes: the request is a single-cycle strobe per write.
module host_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic req,
    output logic grant,
    output logic err
);

    logic err_q;

    // Register the refusal of a request made during start-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= req && !ready;
        end
    end

    // Grant is a same-cycle qualification of the request.
    always_comb begin
        grant = req && ready;
        err   = err_q;
    end

    AST_NO_GRANT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !grant); // R8

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req && !ready)); // R9

endmodule

// File: rtl/boot_init_seq.sv
// Module: boot_init_seq (top)
// Start-up sequencer. One timer drives the program copy lane, the
// coefficient copy lane and the data-clearing lane in parallel. It holds
// the register file clear and gates host writes until the fixed window
// has expired.
// Assumes: every depth is between 1 and INIT_CYCLES, and the boot images
// read combinationally.
module boot_init_seq
    import boot_init_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 8192,
    parameter int unsigned PROG_DEPTH  = 1024,
    parameter int unsigned PROG_W      = 32,
    parameter int unsigned COEF_DEPTH  = 1024,
    parameter int unsigned COEF_W      = 28,
    parameter int unsigned DATA_DEPTH  = 2048,
    parameter int unsigned DATA_W      = 24,
    localparam int unsigned PROG_AW    = width_for(PROG_DEPTH),
    localparam int unsigned COEF_AW    = width_for(COEF_DEPTH),
    localparam int unsigned DATA_AW    = width_for(DATA_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PROG_AW-1:0] prog_rom_addr,
    input  logic [PROG_W-1:0]  prog_rom_data,
    output logic               prog_we,
    output logic [PROG_AW-1:0] prog_addr,
    output logic [PROG_W-1:0]  prog_wdata,
    output logic [COEF_AW-1:0] coef_rom_addr,
    input  logic [COEF_W-1:0]  coef_rom_data,
    output logic               coef_we,
    output logic [COEF_AW-1:0] coef_addr,
    output logic [COEF_W-1:0]  coef_wdata,
    output logic               data_we,
    output logic [DATA_AW-1:0] data_addr,
    output logic [DATA_W-1:0]  data_wdata,
    output logic               regs_clear,
    output logic               busy,
    input  logic               host_wr_req,
    output logic               host_wr_grant,
    output logic               host_wr_err
);

    localparam int unsigned CW          = width_for(INIT_CYCLES);
    localparam int unsigned LOAD_CYCLES = max2(max2(PROG_DEPTH, COEF_DEPTH), DATA_DEPTH);

    logic [CW-1:0] cnt;
    logic          running;
    logic          ready;

    init_timer #(
        .INIT_CYCLES (INIT_CYCLES),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .running (running),
        .ready   (ready)
    );

    rom_copy_lane #(
        .DEPTH (PROG_DEPTH),
        .DW    (PROG_W),
        .CW    (CW)
    ) u_prog_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .cnt       (cnt),
        .rom_addr  (prog_rom_addr),
        .rom_data  (prog_rom_data),
        .ram_we    (prog_we),
        .ram_addr  (prog_addr),
        .ram_wdata (prog_wdata)
    );

    rom_copy_lane #(
        .DEPTH (COEF_DEPTH),
        .DW    (COEF_W),
        .CW    (CW)
    ) u_coef_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .cnt       (cnt),
        .rom_addr  (coef_rom_addr),
        .rom_data  (coef_rom_data),
        .ram_we    (coef_we),
        .ram_addr  (coef_addr),
        .ram_wdata (coef_wdata)
    );

    zero_fill_lane #(
        .DEPTH (DATA_DEPTH),
        .DW    (DATA_W),
        .CW    (CW)
    ) u_data_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .cnt       (cnt),
        .ram_we    (data_we),
        .ram_addr  (data_addr),
        .ram_wdata (data_wdata)
    );

    host_write_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready),
        .req   (host_wr_req),
        .grant (host_wr_grant),
        .err   (host_wr_err)
    );

    // Status outputs: busy and the register clear both last until ready.
    always_comb begin
        busy       = !ready;
        regs_clear = !ready;
    end

    AST_BUSY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> busy); // R1

    AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy); // R2

    AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we || coef_we || data_we) |-> busy); // R6

    AST_NO_WRITE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !(prog_we || coef_we || data_we)); // R10

endmodule

// File: tb/boot_init_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for boot_init_seq, small build so every cycle is checked.
module boot_init_seq_bench;

    localparam int INIT  = 64;
    localparam int PD    = 20;
    localparam int PW    = 16;
    localparam int CD    = 12;
    localparam int CWD   = 12;
    localparam int DD    = 40;
    localparam int DW    = 8;
    localparam int PAW   = $clog2(PD);
    localparam int CAW   = $clog2(CD);
    localparam int DAW   = $clog2(DD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr_req = 1'b0;
    logic [PAW-1:0] prog_rom_addr, prog_addr;
    logic [PW-1:0]  prog_rom_data, prog_wdata;
    logic [CAW-1:0] coef_rom_addr, coef_addr;
    logic [CWD-1:0] coef_rom_data, coef_wdata;
    logic [DAW-1:0] data_addr;
    logic [DW-1:0]  data_wdata;
    logic prog_we, coef_we, data_we, regs_clear, busy, host_wr_grant, host_wr_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [PW-1:0] prog_img(input int a);
        return PW'(a * 97) ^ 16'h5A3C;
    endfunction

    function automatic logic [CWD-1:0] coef_img(input int a);
        return CWD'(a * 13) + 12'h321;
    endfunction

    assign prog_rom_data = prog_img(int'(prog_rom_addr));
    assign coef_rom_data = coef_img(int'(coef_rom_addr));

    boot_init_seq #(
        .INIT_CYCLES (INIT), .PROG_DEPTH (PD), .PROG_W (PW),
        .COEF_DEPTH (CD), .COEF_W (CWD), .DATA_DEPTH (DD), .DATA_W (DW)
    ) u_boot_init_seq (
        .clk (clk), .rst_n (rst_n),
        .prog_rom_addr (prog_rom_addr), .prog_rom_data (prog_rom_data),
        .prog_we (prog_we), .prog_addr (prog_addr), .prog_wdata (prog_wdata),
        .coef_rom_addr (coef_rom_addr), .coef_rom_data (coef_rom_data),
        .coef_we (coef_we), .coef_addr (coef_addr), .coef_wdata (coef_wdata),
        .data_we (data_we), .data_addr (data_addr), .data_wdata (data_wdata),
        .regs_clear (regs_clear), .busy (busy),
        .host_wr_req (host_wr_req), .host_wr_grant (host_wr_grant),
        .host_wr_err (host_wr_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sample cycles 0..ncyc-1 after a release; score every lane per cycle.
    task automatic run_and_score(input int ncyc, output int first_low,
                                 output int ep, output int ec, output int ed, output int er);
        first_low = -1; ep = 0; ec = 0; ed = 0; er = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk); #1;
            if (!busy && first_low < 0) first_low = k;
            if (busy && first_low >= 0) first_low = -2;
            if (prog_we !== (k < PD)) ep++;
            else if (k < PD && (int'(prog_addr) != k || int'(prog_rom_addr) != k
                                || prog_wdata !== prog_img(k))) ep++;
            if (coef_we !== (k < CD)) ec++;
            else if (k < CD && (int'(coef_addr) != k || int'(coef_rom_addr) != k
                                || coef_wdata !== coef_img(k))) ec++;
            if (data_we !== (k < DD)) ed++;
            else if (k < DD && (int'(data_addr) != k || data_wdata !== '0)) ed++;
            if (regs_clear !== busy) er++;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        host_wr_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(busy === 1'b1, "R1 busy in reset", 32'(busy), 1);
        chk({prog_we, coef_we, data_we} === 3'b000, "R1 strobes in reset",
            32'({prog_we, coef_we, data_we}), 0);
        chk(regs_clear === 1'b1, "R7 clear in reset", 32'(regs_clear), 1);
        chk(host_wr_grant === 1'b0, "R8 no grant in reset", 32'(host_wr_grant), 0);
        chk(host_wr_err === 1'b0, "R9 no error in reset", 32'(host_wr_err), 0);
        host_wr_req = 1'b0;
    endtask

    task automatic t_full_init();
        int fl, ep, ec, ed, er;
        @(negedge clk);
        rst_n = 1'b1;
        run_and_score(INIT + 12, fl, ep, ec, ed, er);
        chk(fl == INIT, "R2 busy length", 32'(fl), INIT);
        chk(ep == 0, "R3 program copy", 32'(ep), 0);
        chk(ec == 0, "R4 coefficient copy", 32'(ec), 0);
        chk(ed == 0, "R5 data clear", 32'(ed), 0);
        chk(er == 0, "R7 register clear tracks busy", 32'(er), 0);
        chk({prog_we, coef_we, data_we} === 3'b000, "R6 no writes after init",
            32'({prog_we, coef_we, data_we}), 0);
    endtask

    task automatic t_host_ready();
        @(negedge clk);
        host_wr_req = 1'b1;
        #1;
        chk(host_wr_grant === 1'b1, "R8 grant when ready", 32'(host_wr_grant), 1);
        @(negedge clk);
        host_wr_req = 1'b0;
        #1;
        chk(host_wr_err === 1'b0, "R9 no error when ready", 32'(host_wr_err), 0);
        chk(host_wr_grant === 1'b0, "R8 grant follows request", 32'(host_wr_grant), 0);
    endtask

    task automatic t_host_busy();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        host_wr_req = 1'b1;
        #1;
        chk(host_wr_grant === 1'b0, "R8 no grant while busy", 32'(host_wr_grant), 0);
        @(negedge clk);
        host_wr_req = 1'b0;
        #1;
        chk(host_wr_err === 1'b1, "R9 error after refused write", 32'(host_wr_err), 1);
        @(negedge clk); #1;
        chk(host_wr_err === 1'b0, "R9 error lasts one cycle", 32'(host_wr_err), 0);
    endtask

    task automatic t_abort();
        int fl, ep, ec, ed, er;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_and_score(30, fl, ep, ec, ed, er);
        chk(ep + ec + ed == 0, "R10 partial load before abort", 32'(ep + ec + ed), 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk({prog_we, coef_we, data_we} === 3'b000, "R10 writes stop on abort",
            32'({prog_we, coef_we, data_we}), 0);
        chk(busy === 1'b1, "R10 busy on abort", 32'(busy), 1);
        @(negedge clk);
        rst_n = 1'b1;
        run_and_score(INIT + 4, fl, ep, ec, ed, er);
        chk(fl == INIT, "R10 full length after restart", 32'(fl), INIT);
        chk(ep + ec + ed == 0, "R10 reload from address zero", 32'(ep + ec + ed), 0);
    endtask

    initial begin
        t_reset_state();
        t_full_init();
        t_host_ready();
        t_host_busy();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule